// File: doc/BRIEF.md
# Bus-Matching Port Width Adapter

This block joins a 36-bit memory word to an external data bus whose usable width is chosen at run time: the full 36 bits, 18 bits, or 9 bits. In full-width mode a word crosses the bus in one clock cycle. In the narrow modes the word is cut into two or four slices, and one slice crosses per cycle. A two-bit slice counter inside the block picks the slice for each cycle and steps on its own, so the host gives an address only for the first slice of a word. An endianness input decides whether the most or the least significant slice goes first. Bus pins that the selected width does not use get no output enable, so the pad ring holds them in high impedance.

Reads are flow-through. The word that the memory returns for the current word address is sliced onto the low pins in the same cycle. Writes arrive one slice at a time and are merged into a holding register. The memory write strobe fires once, on the final slice, with the complete merged word. When the slice counter wraps, the word address steps to the next word, so long bursts can run without any new address.

Top module: `bus_match_adapter`

## Requirements
- R1: After synchronous reset, and while no transfer is requested, the word address and the slice counter are zero, `ext_addr` is zero, `bus_oe` is all zero, `bus_dout` is zero and `mem_we` is low.
- R2: `bus_width` encodes the slice width: 2'b00 means 36 bits (one cycle per word), 2'b01 means 18 bits (two cycles), 2'b10 means 9 bits (four cycles), and 2'b11 behaves like 2'b00.
- R3: With `big_end` low, the transfer cycle with slice count c (0 first) carries word bits [W*c +: W] on bus pins [W-1:0], where W is the slice width.
- R4: With `big_end` high, the transfer cycle with slice count c carries word bits [W*(N-1-c) +: W], where N is the number of slices, so the most significant slice comes first.
- R5: In a read transfer cycle, exactly pins [W-1:0] have `bus_oe` set, and the other pins have `bus_oe` clear and `bus_dout` zero. In any cycle with no read transfer, all of `bus_oe` is clear.
- R6: When `strobe` is high, `addr_in` becomes the current word address and the slice count restarts at 0 in that same cycle, even in the middle of a word. Strobe without `xfer` only loads the address.
- R7: Each transfer cycle advances the slice count by one. After the last slice the count returns to 0 and the word address steps by one. `ext_addr` is always {word address, slice count}.
- R8: In narrow write modes `mem_we` is low for all but the last slice. On the last slice it is high, and `mem_wdata` holds the earlier slices together with the current one, each in its own lane.
- R9: In 36-bit mode every write transfer cycle raises `mem_we`, with `mem_wdata` equal to `bus_din`.
- R10: A cycle with neither `xfer` nor `strobe` leaves the word address and the slice count unchanged.
- R11: Stepping past the highest word address wraps to word address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_width | input | 2 | Slice width select (see R2) |
| big_end | input | 1 | 1: most significant slice first |
| xfer | input | 1 | Move one slice this cycle |
| wr | input | 1 | 1: write transfer, 0: read transfer |
| strobe | input | 1 | Load `addr_in` as the word address and restart the slice count |
| addr_in | input | ADDR_W | External word address |
| bus_din | input | 36 | Data from the external bus |
| bus_dout | output | 36 | Data to the external bus, slice on the low pins |
| bus_oe | output | 36 | Output enable for each pin |
| ext_addr | output | ADDR_W+2 | Word address extended by the slice count |
| mem_addr | output | ADDR_W | Word address to the memory |
| mem_rdata | input | 36 | Word that the memory returns for `mem_addr` |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 36 | Merged word to write |

## Verification
Two functions can fall in the same cycle. A strobe can arrive on a transfer cycle, in the middle of a word or on a word boundary. A slice-count wrap can also land on the final write slice, so the word commit and the address step happen together. The bench provokes both: it strobes a new address part way through an 18-bit read, and it runs write bursts whose last slice is also the step past the top word address. A behavioural model tracks the word address, the slice count and the held lanes. On every clock it predicts the bus data, the pin enables, the extended address and the memory write, and the bench compares each of these against the design.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int SUB_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        BW_X36  = 2'b00,
        BW_X18  = 2'b01,
        BW_X9   = 2'b10,
        BW_ALT  = 2'b11
    } bw_e;

    typedef logic [LANES-1:0][LANE_W-1:0] lanes_t;

    // Per-cycle slice selection handed from the counter to the datapaths.
    typedef struct packed {
        logic [SUB_W-1:0] pos;    // slice index in the word, 0 = least significant
        logic [SUB_W-1:0] shift;  // log2 of lanes per slice
        logic             last;   // current slice closes the word
    } slice_t;

    function automatic logic [SUB_W-1:0] last_of(input logic [1:0] bw);
        case (bw)
            BW_X18:  return SUB_W'(1);
            BW_X9:   return SUB_W'(3);
            default: return SUB_W'(0);
        endcase
    endfunction

    function automatic logic [SUB_W-1:0] shift_of(input logic [1:0] bw);
        case (bw)
            BW_X18:  return SUB_W'(1);
            BW_X9:   return SUB_W'(0);
            default: return SUB_W'(2);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] mask_of(input logic [1:0] bw);
        case (bw)
            BW_X18:  return {{(WORD_W-2*LANE_W){1'b0}}, {(2*LANE_W){1'b1}}};
            BW_X9:   return {{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
            default: return {WORD_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/bm_slice_ctrl.sv
module bm_slice_ctrl
    import bm_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_width,
    input  logic              big_end,
    input  logic              strobe,
    input  logic              xfer,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [SUB_W-1:0]  eff_sub,
    output slice_t            slc,
    output logic [ADDR_W-1:0] word_q,
    output logic [SUB_W-1:0]  sub_q
);
    logic [SUB_W-1:0] last;

    always_comb begin
        last      = last_of(bus_width);
        eff_addr  = strobe ? addr_in : word_q;
        eff_sub   = strobe ? '0 : sub_q;
        slc.last  = (eff_sub == last);
        slc.pos   = big_end ? (last - eff_sub) : eff_sub;
        slc.shift = shift_of(bus_width);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            sub_q  <= '0;
        end else if (xfer) begin
            if (slc.last) begin
                sub_q  <= '0;
                word_q <= eff_addr + 1'b1;
            end else begin
                sub_q  <= eff_sub + 1'b1;
                word_q <= eff_addr;
            end
        end else if (strobe) begin
            word_q <= addr_in;
            sub_q  <= '0;
        end
    end
endmodule

// File: rtl/bm_read_lanes.sv
module bm_read_lanes
    import bm_pkg::*;
(
    input  logic [WORD_W-1:0] rdata,
    input  slice_t            slc,
    input  logic              en,
    output logic [WORD_W-1:0] dout,
    output logic [WORD_W-1:0] oe
);
    lanes_t src_l;
    lanes_t out_l;
    lanes_t oe_l;

    assign src_l = rdata;
    assign dout  = out_l;
    assign oe    = oe_l;

    // Bus lane j takes word lane (pos * lanes_per_slice + j) when j lies inside the slice.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            logic [SUB_W:0]   base;
            logic [SUB_W-1:0] sel;
            logic             live;
            base     = {1'b0, slc.pos} << slc.shift;
            sel      = base[SUB_W-1:0] + SUB_W'(j);
            live     = en && ((((SUB_W+1)'(j)) >> slc.shift) == '0);
            out_l[j] = live ? src_l[sel] : '0;
            oe_l[j]  = {LANE_W{live}};
        end
    end
endmodule

// File: rtl/bm_write_gather.sv
module bm_write_gather
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  slice_t            slc,
    input  logic              cap,
    output logic [WORD_W-1:0] wdata
);
    lanes_t din_l;
    lanes_t hold_l;
    lanes_t merged;

    assign din_l = din;
    assign wdata = merged;

    // Word lane i belongs to the current slice when i / lanes_per_slice == pos.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [SUB_W:0]   idx;
            logic [SUB_W:0]   off;
            logic             own;
            idx       = (SUB_W+1)'(i);
            own       = ((idx >> slc.shift) == {1'b0, slc.pos});
            off       = idx - ({1'b0, slc.pos} << slc.shift);
            merged[i] = (cap && own) ? din_l[off[SUB_W-1:0]] : hold_l[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l <= '0;
        end else if (cap) begin
            hold_l <= merged;
        end
    end
endmodule

// File: rtl/bus_match_adapter.sv
module bus_match_adapter
    import bm_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              bus_width,
    input  logic                    big_end,
    input  logic                    xfer,
    input  logic                    wr,
    input  logic                    strobe,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic [WORD_W-1:0]       bus_din,
    output logic [WORD_W-1:0]       bus_dout,
    output logic [WORD_W-1:0]       bus_oe,
    output logic [ADDR_W+SUB_W-1:0] ext_addr,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    mem_we,
    output logic [WORD_W-1:0]       mem_wdata
);
    logic [ADDR_W-1:0] eff_addr;
    logic [SUB_W-1:0]  eff_sub;
    logic [ADDR_W-1:0] word_q;
    logic [SUB_W-1:0]  sub_q;
    slice_t            slc;

    bm_slice_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_width (bus_width),
        .big_end   (big_end),
        .strobe    (strobe),
        .xfer      (xfer),
        .addr_in   (addr_in),
        .eff_addr  (eff_addr),
        .eff_sub   (eff_sub),
        .slc       (slc),
        .word_q    (word_q),
        .sub_q     (sub_q)
    );

    bm_read_lanes u_rd (
        .rdata (mem_rdata),
        .slc   (slc),
        .en    (xfer && !wr),
        .dout  (bus_dout),
        .oe    (bus_oe)
    );

    bm_write_gather u_wr (
        .clk   (clk),
        .rst   (rst),
        .din   (bus_din),
        .slc   (slc),
        .cap   (xfer && wr),
        .wdata (mem_wdata)
    );

    assign mem_addr = eff_addr;
    assign ext_addr = {eff_addr, eff_sub};
    assign mem_we   = xfer && wr && slc.last;
endmodule

// File: rtl/bm_adapter_chk.sv
module bm_adapter_chk
    import bm_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    xfer,
    input logic                    wr,
    input logic                    strobe,
    input logic [1:0]              bus_width,
    input logic [WORD_W-1:0]       bus_oe,
    input logic                    mem_we,
    input logic [ADDR_W+SUB_W-1:0] ext_addr,
    input logic [ADDR_W-1:0]       word_q,
    input logic [SUB_W-1:0]        sub_q
);
    logic [SUB_W-1:0] cur_sub;
    logic             at_end;
    assign cur_sub = ext_addr[SUB_W-1:0];
    assign at_end  = (cur_sub == last_of(bus_width));

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (word_q == '0 && sub_q == '0)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !xfer |-> (bus_oe == '0 && !mem_we)); // R5

    AST_OE_LANES: assert property (@(posedge clk) disable iff (rst)
        (xfer && !wr) |-> (bus_oe == mask_of(bus_width))); // R5

    AST_WE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (xfer && wr && at_end)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!xfer && !strobe) |=> (word_q == $past(word_q) && sub_q == $past(sub_q))); // R10

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
        (xfer && at_end) |=> (sub_q == '0)); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer && at_end) |=> (word_q == ADDR_W'($past(ext_addr[ADDR_W+SUB_W-1:SUB_W]) + 1'b1))); // R11
endmodule

bind bus_match_adapter bm_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .wr        (wr),
    .strobe    (strobe),
    .bus_width (bus_width),
    .bus_oe    (bus_oe),
    .mem_we    (mem_we),
    .ext_addr  (ext_addr),
    .word_q    (word_q),
    .sub_q     (sub_q)
);

// File: tb/bus_match_adapter_test.sv
`timescale 1ns/1ps
module bus_match_adapter_test;
    localparam int AW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic [1:0]    bus_width = 2'b00;
    logic          big_end = 1'b0;
    logic          xfer = 1'b0;
    logic          wr = 1'b0;
    logic          strobe = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [35:0]   bus_din = '0;
    logic [35:0]   bus_dout, bus_oe, mem_rdata, mem_wdata;
    logic [AW+1:0] ext_addr;
    logic [AW-1:0] mem_addr;
    logic          mem_we;

    logic [35:0] mem [64];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    bus_match_adapter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_width(bus_width), .big_end(big_end),
        .xfer(xfer), .wr(wr), .strobe(strobe), .addr_in(addr_in),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .ext_addr(ext_addr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    int tests = 0;
    int fails = 0;
    int m_addr = 0;
    int m_sub = 0;
    logic [35:0] m_buf = '0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic xf, input logic st, input logic w,
                        input logic [AW-1:0] a, input logic [35:0] d, input string tag);
        int n, wd, k, ea, es;
        logic [35:0] msk, word, e_dout, e_oe;
        logic e_we;
        @(negedge clk);
        xfer = xf; strobe = st; wr = w; addr_in = a; bus_din = d;
        #1;
        n  = (bus_width == 2'b01) ? 2 : (bus_width == 2'b10) ? 4 : 1;
        wd = 36 / n;
        ea = st ? int'(a) : m_addr;
        es = st ? 0 : m_sub;
        k  = big_end ? (n - 1 - es) : es;
        msk = (wd == 36) ? '1 : ((36'd1 << wd) - 36'd1);
        e_dout = '0;
        e_oe   = '0;
        if (xf && !w) begin
            e_dout = (mem[ea] >> (wd * k)) & msk;
            e_oe   = msk;
        end
        word = m_buf;
        if (xf && w) for (int b = 0; b < wd; b++) word[wd * k + b] = d[b];
        e_we = xf && w && (es == n - 1);
        chk(tag, "bus_dout", 64'(bus_dout), 64'(e_dout));
        chk(tag, "bus_oe",   64'(bus_oe),   64'(e_oe));
        chk(tag, "ext_addr", 64'(ext_addr), 64'(ea * 4 + es));
        chk(tag, "mem_addr", 64'(mem_addr), 64'(ea));
        chk(tag, "mem_we",   64'(mem_we),   64'(e_we));
        if (e_we) chk(tag, "mem_wdata", 64'(mem_wdata), 64'(word));
        @(posedge clk);
        if (xf) begin
            if (w) m_buf = word;
            if (es == n - 1) begin
                m_sub  = 0;
                m_addr = (ea + 1) % 64;
            end else begin
                m_sub  = es + 1;
                m_addr = ea;
            end
        end else if (st) begin
            m_addr = int'(a);
            m_sub  = 0;
        end
    endtask

    task automatic mode(input logic [1:0] bw, input logic be);
        @(negedge clk);
        bus_width = bw;
        big_end = be;
    endtask

    initial begin
        #(200000 * 5);
        tests++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 36'h9_A5C3_1E07 ^ (36'(i) * 36'h0_0F1B_3C5D);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        step(0, 0, 0, '0, '0, "R1");

        // R9 / R2: full width write and read, reserved code acts as full
        mode(2'b00, 0);
        step(1, 1, 1, 6'd5, 36'hC_3A5A_1234, "R9");
        step(1, 1, 0, 6'd5, '0, "R2");
        mode(2'b11, 0);
        step(1, 1, 0, 6'd5, '0, "R2");
        step(1, 0, 1, '0, 36'h1_2345_6789, "R9");

        // R8 / R3: 18-bit little endian write then read
        mode(2'b01, 0);
        step(1, 1, 1, 6'd10, 36'h0_0003_1111, "R8");
        step(1, 0, 1, '0, 36'h0_0002_2222, "R8");
        step(1, 1, 0, 6'd10, '0, "R3");
        step(1, 0, 0, '0, '0, "R5");

        // R4: 9-bit big endian write and read, then little endian read
        mode(2'b10, 1);
        step(1, 1, 1, 6'd20, 36'h0_0000_01AB, "R4");
        step(1, 0, 1, '0, 36'h0_0000_0123, "R8");
        step(1, 0, 1, '0, 36'h0_0000_0045, "R8");
        step(1, 0, 1, '0, 36'h0_0000_01F0, "R8");
        step(1, 1, 0, 6'd20, '0, "R4");
        step(1, 0, 0, '0, '0, "R4");
        step(1, 0, 0, '0, '0, "R5");
        step(1, 0, 0, '0, '0, "R4");
        mode(2'b10, 0);
        step(1, 1, 0, 6'd20, '0, "R3");
        step(1, 0, 0, '0, '0, "R3");

        // R10: idle gaps inside a word keep the position
        step(1, 1, 0, 6'd21, '0, "R10");
        step(0, 0, 0, '0, '0, "R10");
        step(0, 0, 1, '0, '0, "R10");
        step(1, 0, 0, '0, '0, "R10");
        step(1, 0, 0, '0, '0, "R10");
        step(1, 0, 0, '0, '0, "R10");

        // R7: burst across two words with no new address
        step(1, 1, 0, 6'd30, '0, "R7");
        for (int c = 0; c < 7; c++) step(1, 0, 0, '0, '0, "R7");

        // R6: strobe in the middle of a word, and strobe without transfer
        mode(2'b01, 1);
        step(1, 1, 0, 6'd40, '0, "R6");
        step(1, 1, 0, 6'd41, '0, "R6");
        step(1, 0, 0, '0, '0, "R6");
        step(0, 1, 0, 6'd12, '0, "R6");
        step(1, 0, 0, '0, '0, "R6");

        // R11: wrap from the top word, commit coinciding with the wrap
        step(1, 1, 1, 6'd63, 36'h0_0001_5555, "R11");
        step(1, 0, 1, '0, 36'h0_0002_AAAA, "R11");
        step(1, 0, 1, '0, 36'h0_0000_7777, "R11");
        step(1, 0, 1, '0, 36'h0_0003_0F0F, "R11");
        step(1, 1, 0, 6'd63, '0, "R11");
        step(1, 0, 0, '0, '0, "R11");
        step(1, 0, 0, '0, '0, "R11");
        step(1, 0, 0, '0, '0, "R11");
        step(0, 0, 0, '0, '0, "R5");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule